// File: doc/BRIEF.md
# Round-Robin Parallel FFT Scheduler

This controller lets eight identical FFT engines, each too slow on its own, together keep up with one continuous complex sample stream arriving at one sample per clock. It splits the stream into blocks of `BLK_LEN` samples and writes each block into the next engine in fixed rotation. When a block is complete, it sends that engine a one-cycle start pulse. Seven block slots later, it reads that engine's result out through a shared, registered output multiplexer.

There is no handshaking. A single free-running counter of width log2(8·BLK_LEN) runs the whole schedule. Its upper bits select the engine being written. That index plus one, modulo 8, selects the engine being read. Its lower bits form the one address that every engine receives. Each engine's transform time must fit into the six slots between its write slot and its read slot. For a 1024-point engine with 8-bit twiddles this is 5205 of 6144 cycles. An engine whose done level is still low when its read window opens raises a sticky overrun flag, and the read goes ahead anyway. Engines are assumed to return read data combinationally, in the same cycle as the address.

Top module: `rr_fft_sched`

## Requirements
- R1: During and directly after reset, `addr` is 0, `wr_en` selects engine 0, and `eng_start`, `rd_en`, `out_valid`, `out_sof` and `overrun` are all 0.
- R2: In the t-th cycle after reset, `wr_en` is one-hot at bit (t / BLK_LEN) mod NUM_ENG, `addr` equals t mod BLK_LEN, and `wr_data` equals `in_data` in that same cycle.
- R3: In the cycle after an engine's last write address (BLK_LEN-1), that engine's bit of `eng_start` is high for exactly one cycle. All other start bits are 0.
- R4: Once reading is live, `rd_en` is one-hot at bit ((t / BLK_LEN) + 1) mod NUM_ENG. It never selects the engine being written.
- R5: `rd_en` and `out_valid` stay 0 until the first read window opens, at cycle (NUM_ENG-1)·BLK_LEN after reset. From then on they stay live.
- R6: `out_data` is the read word of the engine selected by `rd_en`, registered, and appears one cycle after that engine is addressed.
- R7: `out_sof` is high, together with `out_valid`, exactly for the output word read at address 0 of each window.
- R8: If the selected engine's `eng_done` bit is low in the first cycle of its read window, `overrun` rises on the next cycle and stays high until reset. Otherwise it stays 0.
- R9: The schedule repeats every NUM_ENG·BLK_LEN cycles, so engine 0 is written again starting at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 2*DW | Complex input sample, one per cycle |
| wr_data | output | 2*DW | Sample forwarded to all engines |
| addr | output | log2(BLK_LEN) | Shared write/read address |
| wr_en | output | NUM_ENG | One-hot write enable per engine |
| eng_start | output | NUM_ENG | One-cycle start pulse per engine |
| eng_done | input | NUM_ENG | Per-engine done level |
| eng_rd_data | input | NUM_ENG*2*DW | Read words, engine k at bits [k*2*DW +: 2*DW] |
| rd_en | output | NUM_ENG | One-hot read select per engine |
| out_data | output | 2*DW | Registered result word |
| out_valid | output | 1 | Result word valid |
| out_sof | output | 1 | First word of a result block |
| overrun | output | 1 | Sticky late-engine flag |

## Verification
The bench builds the block with NUM_ENG = 8, BLK_LEN = 16 and DW = 8. This makes the full period 128 cycles, so a run covers many complete rotations, every engine's write-to-read transition, and the wrap of the counter. The short blocks also bring the first-read-window boundary at cycle 112 within easy reach, as well as a mid-run reset. Random `eng_done` drops in one phase exercise the overrun flag, and a quiet phase shows that it stays low.

// File: rtl/rr_fft_sched.sv
module rr_fft_sched #(
  parameter int NUM_ENG = 8,
  parameter int BLK_LEN = 1024,
  parameter int DW      = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2*DW-1:0]           in_data,
  output logic [2*DW-1:0]           wr_data,
  output logic [$clog2(BLK_LEN)-1:0] addr,
  output logic [NUM_ENG-1:0]        wr_en,
  output logic [NUM_ENG-1:0]        eng_start,
  input  logic [NUM_ENG-1:0]        eng_done,
  input  logic [NUM_ENG*2*DW-1:0]   eng_rd_data,
  output logic [NUM_ENG-1:0]        rd_en,
  output logic [2*DW-1:0]           out_data,
  output logic                      out_valid,
  output logic                      out_sof,
  output logic                      overrun
);
  localparam int AW = $clog2(BLK_LEN);
  localparam int EW = $clog2(NUM_ENG);
  localparam int CW = AW + EW;
  localparam int W2 = 2 * DW;
  localparam logic [CW-1:0] FIRST_RD = CW'((NUM_ENG - 1) * BLK_LEN);
  localparam logic [AW-1:0] LAST_ADR = AW'(BLK_LEN - 1);
  localparam logic [NUM_ENG-1:0] ONE = NUM_ENG'(1);

  logic [CW-1:0] cnt;
  logic [EW-1:0] wr_idx, rd_idx;
  logic          live_q, rd_act;

  assign wr_idx  = cnt[CW-1:AW];
  assign rd_idx  = wr_idx + EW'(1);
  assign addr    = cnt[AW-1:0];
  assign wr_data = in_data;
  assign wr_en   = ONE << wr_idx;
  assign rd_act  = live_q | (cnt == FIRST_RD);
  assign rd_en   = rd_act ? (ONE << rd_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      live_q    <= 1'b0;
      eng_start <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      cnt       <= cnt + CW'(1);
      live_q    <= rd_act;
      eng_start <= (addr == LAST_ADR) ? (ONE << wr_idx) : '0;
      out_data  <= eng_rd_data[rd_idx*W2 +: W2];
      out_valid <= rd_act;
      out_sof   <= rd_act && (addr == '0);
      if (rd_act && addr == '0 && !eng_done[rd_idx])
        overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/rr_fft_sched_chk.sv
module rr_fft_sched_chk #(
  parameter int NUM_ENG = 8,
  parameter int BLK_LEN = 1024
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [$clog2(BLK_LEN)-1:0] addr,
  input logic [NUM_ENG-1:0]         wr_en,
  input logic [NUM_ENG-1:0]         eng_start,
  input logic [NUM_ENG-1:0]         rd_en,
  input logic                       out_valid,
  input logic                       out_sof,
  input logic                       overrun
);
  // R2
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_en) == 1);
  // R3
  start_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eng_start));
  // R3
  start_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start != '0) |-> ($past(addr) == {$bits(addr){1'b1}} && eng_start == $past(wr_en)));
  // R4
  rd_not_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_en) && ((rd_en & wr_en) == '0));
  // R5
  valid_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(rd_en) != '0));
  // R7
  sof_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);
  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

bind rr_fft_sched rr_fft_sched_chk #(.NUM_ENG(NUM_ENG), .BLK_LEN(BLK_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .eng_start(eng_start),
  .rd_en(rd_en), .out_valid(out_valid), .out_sof(out_sof), .overrun(overrun)
);

// File: tb/rr_fft_sched_bench.sv
module rr_fft_sched_bench;
  localparam int NE = 8, N = 16, DW = 8, W2 = 2 * DW, P = NE * N, AW = $clog2(N);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic [W2-1:0] in_data = '0, wr_data, out_data;
  logic [AW-1:0] addr;
  logic [NE-1:0] wr_en, eng_start, eng_done = '1, rd_en;
  logic [NE*W2-1:0] eng_rd_data = '0;
  logic out_valid, out_sof, overrun;

  rr_fft_sched #(.NUM_ENG(NE), .BLK_LEN(N), .DW(DW)) u_rr_fft_sched (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .wr_data(wr_data), .addr(addr),
    .wr_en(wr_en), .eng_start(eng_start), .eng_done(eng_done),
    .eng_rd_data(eng_rd_data), .rd_en(rd_en), .out_data(out_data),
    .out_valid(out_valid), .out_sof(out_sof), .overrun(overrun));

  int checks = 0, fails = 0, t = 0;
  bit quiet = 1'b1;
  logic [NE-1:0] exp_start;
  logic [W2-1:0] exp_od;
  bit exp_ov, exp_sof, exp_ovr;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0d)", req, act, exp, t);
    end
  endtask

  function automatic logic [NE-1:0] oh(input int i);
    return NE'(1) << i;
  endfunction

  function automatic bit live(input int tt);
    return tt >= (NE - 1) * N;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 addr", addr, 0);
    chk("R1 start", eng_start, 0);
    chk("R1 rd_en", rd_en, 0);
    chk("R1 valid", out_valid, 0);
    chk("R1 sof", out_sof, 0);
    chk("R1 overrun", overrun, 0);
    rst_n = 1'b1;
    #1;
    chk("R1 wr_en", wr_en, 1);
    t = 0; exp_start = '0; exp_od = '0; exp_ov = 0; exp_sof = 0; exp_ovr = 0;
  endtask

  task automatic run(input int cycles);
    for (int c = 0; c < cycles; c++) begin
      if (c != 0) @(negedge clk);
      in_data = W2'($urandom);
      for (int e = 0; e < NE; e++) eng_rd_data[e*W2 +: W2] = W2'($urandom);
      eng_done = quiet ? '1 : NE'($urandom | $urandom | $urandom);
      #1;
      chk("R2 wr_en", wr_en, oh((t / N) % NE));
      chk("R2 addr", addr, t % N);
      chk("R2 wr_data", wr_data, in_data);
      if (t > 0 && t % P == 0) chk("R9 wrap", {wr_en, addr}, {oh(0), AW'(0)});
      chk("R4/R5 rd_en", rd_en, live(t) ? oh((t / N + 1) % NE) : 0);
      chk("R3 start", eng_start, exp_start);
      chk("R5 valid", out_valid, exp_ov);
      if (exp_ov) chk("R6 data", out_data, exp_od);
      chk("R7 sof", out_sof, exp_sof);
      chk("R8 overrun", overrun, exp_ovr);
      exp_start = (t % N == N - 1) ? oh((t / N) % NE) : '0;
      exp_ov    = live(t);
      exp_od    = eng_rd_data[((t / N + 1) % NE)*W2 +: W2];
      exp_sof   = live(t) && (t % N == 0);
      if (live(t) && t % N == 0 && !eng_done[(t / N + 1) % NE]) exp_ovr = 1'b1;
      @(posedge clk);
      t++;
    end
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL R9 watchdog actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    quiet = 1'b1;
    run(600);
    quiet = 1'b0;
    run(500);
    do_reset();
    quiet = 1'b1;
    run(300);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule